// File: doc/BRIEF.md
# Eight-Region Access Protection Checker

This block sits beside a bus master and judges every access it issues against eight protection windows that software programs. Each access has an address, a kind (instruction fetch, data read or data write) and a privilege level. One cycle later the block returns a verdict: permitted or faulted. With the verdict it returns the window that decided the outcome, that window's no-execute flag and an eight-bit attribute byte for the memory system downstream.

Windows may overlap, and the window with the higher index decides. Each window covers a power-of-two span between 256 bytes and 4 GB, starting on a boundary of its own size. The window is cut into eighths, and software can switch each eighth off. An address in an eighth that is switched off falls through to lower-numbered windows. If no window claims the address, a global option lets privileged accesses through on a default map. The system area at 0xE0000000–0xEFFFFFFF always passes. While the unit is switched off, every access passes.

Configuration uses a single word-wide write port and a combinational read port. Each window has two words, a base word and an attribute word. A separate control word holds the global switches.

Top module: `region_guard`

## Requirements
- R1: After reset `res_valid`, `res_permit` and `res_fault` are 0. Every stored configuration word reads back as 0, so all windows are off, the unit is off and the background map is off.
- R2: A write (`cfg_we`=1) takes effect at the next clock edge. Select 0 writes the base word, keeping bits 31:8. Select 1 writes the attribute word, keeping the mask 0x0FFFFF3F. Select 2 writes the control word, bit 0 = unit on, bit 1 = background map. Select 3 is ignored. Reads return the stored values with the bits that are not kept read as 0. Attribute word fields: bit 0 window on, bits 5:1 size code S, bits 15:8 eighth-disable mask, bits 18:16 access code, bit 19 no-execute, bits 27:20 attribute byte.
- R3: A window with size code S spans 2^(S+1) bytes and ignores base bits below S+1. The valid range is S = 7 (256 B) to S = 31 (4 GB). A window with S < 7 never matches.
- R4: When several windows match, the highest index wins. Its index appears on `res_region` and `res_hit` is 1.
- R5: Eighth number k of a window is selected by address bits [S:S-2]. If bit 8+k of the attribute word is set, the window does not match that address, and lower windows or the background decide.
- R6: Access code, privileged / unprivileged. 0 and 4 deny everything. 1 gives privileged read/write only. 2 gives privileged read/write plus unprivileged read. 3 gives read/write to all. 5 gives privileged read only. 6 and 7 give read to all.
- R7: An instruction fetch (`acc_kind`=0) needs read rights and a winning window without no-execute; otherwise it faults. Data reads ignore no-execute, and `res_xn` reports the flag.
- R8: With no matching window, a privileged access passes only if the background map is on. Otherwise it faults. `res_hit`, `res_region`, `res_xn` and `res_attr` are 0.
- R9: While the unit is off, every access passes with `res_hit`=0 and zero attributes.
- R10: While the unit is on, an address with bits 31:28 = 0xE always passes with `res_hit`=0, whatever the windows hold.
- R11: The verdict for an access presented with `acc_valid`=1 appears one cycle later with `res_valid`=1 and `res_fault` = !`res_permit`. Without an access, every result output is 0. Kind code 1 is a data read, kind code 2 a data write, and kind code 3 is treated as a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word written: 0 base, 1 attributes, 2 control |
| cfg_idx | input | 3 | Window written |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 2 | Word read |
| cfg_ridx | input | 3 | Window read |
| cfg_rdata | output | 32 | Stored word (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| acc_priv | input | 1 | 1 = privileged |
| res_valid | output | 1 | Verdict present |
| res_permit | output | 1 | Access allowed |
| res_fault | output | 1 | Access refused |
| res_hit | output | 1 | A window decided |
| res_region | output | 3 | Deciding window |
| res_xn | output | 1 | No-execute flag of the deciding window |
| res_attr | output | 8 | Attribute byte of the deciding window |

## Verification
Accesses are first made inside a single window, then in nested windows where a small high-numbered window sits inside a large low one. This separates the rule that the highest index wins from a first-match scan. An access into a disabled eighth of the small window must land on the large one, which shows that the fall-through goes to the lower window and not straight to the background. The access codes are swept over both privilege levels and both data directions, and fetches are run against a no-execute window. A minimum-size window, an undersized code and a 4 GB window probe the size limits, and accesses to the system area and with the unit off show the bypass paths.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int ATTR_W = 8;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RDALT = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [23:0]       base_hi;
        logic              en;
        logic [4:0]        sz;
        logic [7:0]        srd;
        logic [2:0]        ap;
        logic              xn;
        logic [ATTR_W-1:0] attr;
    } region_t;

    localparam logic [31:0] ATTR_KEEP = 32'h0FFF_FF3F;
    localparam logic [4:0]  SZ_MIN    = 5'd7;

    function automatic logic ap_read_ok(logic [2:0] ap, logic priv);
        case (ap)
            3'd1, 3'd5:                   return priv;
            3'd2, 3'd3, 3'd6, 3'd7:       return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic ap_write_ok(logic [2:0] ap, logic priv);
        case (ap)
            3'd1, 3'd2: return priv;
            3'd3:       return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [1:0]                     sel_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [31:0]                    wdata_i,
    input  logic [1:0]                     rsel_i,
    input  logic [IDX_W-1:0]               ridx_i,
    output logic [31:0]                    rdata_o,
    output region_t [NUM_REGIONS-1:0]      regions_o,
    output logic                           unit_en_o,
    output logic                           bg_en_o
);

    typedef struct packed {
        region_t [NUM_REGIONS-1:0] rg;
        logic                      unit_en;
        logic                      bg_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (sel_i)
                2'd0: cfg_d.rg[idx_i].base_hi = wdata_i[31:8];
                2'd1: begin
                    cfg_d.rg[idx_i].en   = wdata_i[0];
                    cfg_d.rg[idx_i].sz   = wdata_i[5:1];
                    cfg_d.rg[idx_i].srd  = wdata_i[15:8];
                    cfg_d.rg[idx_i].ap   = wdata_i[18:16];
                    cfg_d.rg[idx_i].xn   = wdata_i[19];
                    cfg_d.rg[idx_i].attr = wdata_i[27:20];
                end
                2'd2: begin
                    cfg_d.unit_en = wdata_i[0];
                    cfg_d.bg_en   = wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (rsel_i)
            2'd0:    rdata_o = {cfg_q.rg[ridx_i].base_hi, 8'h00};
            2'd1:    rdata_o = {4'h0, cfg_q.rg[ridx_i].attr, cfg_q.rg[ridx_i].xn,
                                cfg_q.rg[ridx_i].ap, cfg_q.rg[ridx_i].srd, 2'b00,
                                cfg_q.rg[ridx_i].sz, cfg_q.rg[ridx_i].en};
            2'd2:    rdata_o = {30'd0, cfg_q.bg_en, cfg_q.unit_en};
            default: rdata_o = 32'd0;
        endcase
    end

    assign regions_o = cfg_q.rg;
    assign unit_en_o = cfg_q.unit_en;
    assign bg_en_o   = cfg_q.bg_en;

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == 2'd2) |=> (unit_en_o == $past(wdata_i[0]) && bg_en_o == $past(wdata_i[1])));

    // R2
    base_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == 2'd0) |=> (regions_o[$past(idx_i)].base_hi == $past(wdata_i[31:8])));

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
(
    input  logic [31:0] addr_i,
    input  region_t     rg_i,
    output logic        hit_o
);

    logic [5:0]  span;
    logic [5:0]  sub_shift;
    logic [32:0] keep_mask;
    logic [31:0] shifted;
    logic [2:0]  sub;
    logic        in_span;

    always_comb begin
        span      = {1'b0, rg_i.sz} + 6'd1;
        sub_shift = {1'b0, rg_i.sz} - 6'd2;
        keep_mask = {33{1'b1}} << span;
        shifted   = addr_i >> sub_shift;
        sub       = shifted[2:0];
        in_span   = ((addr_i ^ {rg_i.base_hi, 8'h00}) & keep_mask[31:0]) == 32'd0;
        hit_o     = rg_i.en && (rg_i.sz >= SZ_MIN) && in_span && !rg_i.srd[sub];
    end

endmodule

// File: rtl/mpu_winner_pick.sv
module mpu_winner_pick #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] match_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R4
    always_comb begin
        if (!$isunknown(match_i) && any_o) begin
            top_winner_chk: assert ((match_i >> idx_o) == {{(NUM_REGIONS-1){1'b0}}, 1'b1});
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [31:0]        cfg_wdata,
    input  logic [1:0]         cfg_rsel,
    input  logic [IDX_W-1:0]   cfg_ridx,
    output logic [31:0]        cfg_rdata,
    input  logic               acc_valid,
    input  logic [31:0]        acc_addr,
    input  logic [1:0]         acc_kind,
    input  logic               acc_priv,
    output logic               res_valid,
    output logic               res_permit,
    output logic               res_fault,
    output logic               res_hit,
    output logic [IDX_W-1:0]   res_region,
    output logic               res_xn,
    output logic [ATTR_W-1:0]  res_attr
);

    typedef struct packed {
        logic              valid;
        logic              permit;
        logic              fault;
        logic              hit;
        logic [IDX_W-1:0]  region;
        logic              xn;
        logic [ATTR_W-1:0] attr;
    } res_t;

    region_t [NUM_REGIONS-1:0] regions;
    logic                      unit_en;
    logic                      bg_en;
    logic [NUM_REGIONS-1:0]    match_vec;
    logic                      any_hit;
    logic [IDX_W-1:0]          win_idx;
    region_t                   win_rg;
    logic                      sys_area;
    logic                      rd_ok;
    logic                      wr_ok;
    res_t                      res_d, res_q;

    mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we),
        .sel_i     (cfg_sel),
        .idx_i     (cfg_idx),
        .wdata_i   (cfg_wdata),
        .rsel_i    (cfg_rsel),
        .ridx_i    (cfg_ridx),
        .rdata_o   (cfg_rdata),
        .regions_o (regions),
        .unit_en_o (unit_en),
        .bg_en_o   (bg_en)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        mpu_region_match u_match (
            .addr_i (acc_addr),
            .rg_i   (regions[g]),
            .hit_o  (match_vec[g])
        );
    end

    mpu_winner_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
        .match_i (match_vec),
        .any_o   (any_hit),
        .idx_o   (win_idx)
    );

    always_comb begin
        win_rg   = regions[win_idx];
        sys_area = (acc_addr[31:28] == 4'hE);
        rd_ok    = ap_read_ok(win_rg.ap, acc_priv);
        wr_ok    = ap_write_ok(win_rg.ap, acc_priv);
        res_d    = '0;
        if (acc_valid) begin
            res_d.valid = 1'b1;
            if (!unit_en || sys_area) begin
                res_d.permit = 1'b1;
            end else if (any_hit) begin
                res_d.hit    = 1'b1;
                res_d.region = win_idx;
                res_d.xn     = win_rg.xn;
                res_d.attr   = win_rg.attr;
                case (acc_kind_e'(acc_kind))
                    ACC_FETCH: res_d.permit = rd_ok && !win_rg.xn;
                    ACC_WRITE: res_d.permit = wr_ok;
                    default:   res_d.permit = rd_ok;
                endcase
            end else begin
                res_d.permit = bg_en && acc_priv;
            end
            res_d.fault = !res_d.permit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_permit = res_q.permit;
    assign res_fault  = res_q.fault;
    assign res_hit    = res_q.hit;
    assign res_region = res_q.region;
    assign res_xn     = res_q.xn;
    assign res_attr   = res_q.attr;

    // R9
    unit_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !unit_en) |=> (res_permit && !res_hit));

    // R10
    sys_area_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[31:28] == 4'hE) |=> (res_permit && !res_hit));

    // R7
    xn_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd0 && unit_en && acc_addr[31:28] != 4'hE && any_hit && win_rg.xn)
        |=> res_fault);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!res_valid && !res_permit && !res_fault));

endmodule

// File: tb/region_guard_tb_top.sv
module region_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_rsel = '0;
    logic [2:0]  cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0;
    logic        res_valid, res_permit, res_fault, res_hit, res_xn;
    logic [2:0]  res_region;
    logic [7:0]  res_attr;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_base [8];
    logic [31:0] m_attr [8];
    bit          m_en = 0;
    bit          m_bg = 0;

    always #5 clk = ~clk;

    region_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
        .res_valid(res_valid), .res_permit(res_permit), .res_fault(res_fault),
        .res_hit(res_hit), .res_region(res_region), .res_xn(res_xn), .res_attr(res_attr)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference: {permit, hit, region[2:0], xn, attr[7:0]}
    function automatic logic [13:0] ref_eval(logic [31:0] a, int kind, bit priv);
        bit rd, wr, pm;
        if (!m_en || a[31:28] == 4'hE) return {1'b1, 1'b0, 3'd0, 1'b0, 8'h00};
        for (int r = 7; r >= 0; r--) begin
            logic [31:0] at = m_attr[r];
            int sz = int'(at[5:1]);
            longint unsigned size, sub;
            int ap;
            if (!at[0] || sz < 7) continue;
            size = 64'd1 << (sz + 1);
            if ((longint'(a) / size) != (longint'(m_base[r]) / size)) continue;
            sub = (longint'(a) % size) / (size / 8);
            if (at[8 + int'(sub)]) continue;
            ap = int'(at[18:16]);
            rd = (ap == 3 || ap == 6 || ap == 7 || ap == 2) || (priv && (ap == 1 || ap == 5));
            wr = (ap == 3) || (priv && (ap == 1 || ap == 2));
            if (kind == 0)      pm = rd && !at[19];
            else if (kind == 2) pm = wr;
            else                pm = rd;
            return {pm, 1'b1, 3'(r), at[19], at[27:20]};
        end
        return {m_bg && priv, 1'b0, 3'd0, 1'b0, 8'h00};
    endfunction

    task automatic wr_cfg(int sel, int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_base[idx] = d & 32'hFFFF_FF00;
            1: m_attr[idx] = d & 32'h0FFF_FF3F;
            2: begin m_en = d[0]; m_bg = d[1]; end
            default: ;
        endcase
    endtask

    task automatic rd_chk(int sel, int idx, logic [31:0] exp, string tag);
        cfg_rsel = 2'(sel); cfg_ridx = 3'(idx);
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic access(logic [31:0] a, int kind, bit priv, string tag);
        logic [13:0] e;
        logic [13:0] got;
        e = ref_eval(a, kind, priv);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = 2'(kind); acc_priv = priv;
        @(negedge clk);
        acc_valid = 1'b0;
        got = {res_permit, res_hit, res_region, res_xn, res_attr};
        chk(res_valid && (res_fault == !res_permit) && got == e, tag,
            {17'd0, res_valid, got}, {17'd0, 1'b1, e});
    endtask

    function automatic logic [31:0] aword(bit en, int sz, int srd, int ap, bit xn, int attr);
        return {4'h0, 8'(attr), xn, 3'(ap), 8'(srd), 2'b00, 5'(sz), en};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_attr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!res_valid && !res_permit && !res_fault, "R1 outputs", {29'd0, res_valid, res_permit, res_fault}, 32'd0);
        rd_chk(1, 0, 32'd0, "R1 attr word");
        rd_chk(2, 0, 32'd0, "R1 control word");

        // R9 unit off
        access(32'h2000_0000, 2, 1'b0, "R9 unit off write");
        access(32'h1234_5678, 0, 1'b0, "R9 unit off fetch");

        // R2 writes and readback with masks
        wr_cfg(0, 0, 32'h2000_00FF);
        rd_chk(0, 0, 32'h2000_0000, "R2 base mask");
        wr_cfg(1, 0, 32'hFFFF_FFFF);
        rd_chk(1, 0, 32'h0FFF_FF3F, "R2 attr mask");
        wr_cfg(1, 0, aword(1, 15, 0, 3, 0, 8'h11));
        rd_chk(1, 0, aword(1, 15, 0, 3, 0, 8'h11), "R2 attr readback");
        wr_cfg(3, 0, 32'hFFFF_FFFF);
        rd_chk(0, 0, 32'h2000_0000, "R2 select 3 ignored");
        wr_cfg(2, 0, 32'h0000_0001);
        rd_chk(2, 0, 32'h0000_0001, "R2 control");

        // R3 matching, low base bits ignored
        access(32'h2000_1234, 1, 1'b0, "R3 inside window");
        access(32'h2001_0000, 1, 1'b1, "R8 outside no background");
        wr_cfg(0, 1, 32'h3000_4000);
        wr_cfg(1, 1, aword(1, 15, 0, 3, 0, 8'h44));
        access(32'h3000_0004, 2, 1'b0, "R3 base low bits ignored");
        access(32'h3001_0000, 2, 1'b0, "R3 above span");

        // R4 priority
        wr_cfg(0, 2, 32'h2000_0000);
        wr_cfg(1, 2, aword(1, 11, 0, 6, 0, 8'h22));
        access(32'h2000_0100, 2, 1'b1, "R4 high window wins write");
        access(32'h2000_0100, 1, 1'b0, "R4 high window wins read");
        access(32'h2000_2000, 2, 1'b0, "R4 low window outside high");

        // R5 sub-region disable (eighth 1 of 4 KB window = 0x200..0x3FF)
        wr_cfg(1, 2, aword(1, 11, 8'h02, 6, 0, 8'h22));
        access(32'h2000_0300, 2, 1'b0, "R5 disabled eighth falls through");
        access(32'h2000_0400, 2, 1'b0, "R5 enabled eighth still wins");
        access(32'h2000_01FC, 1, 1'b0, "R5 eighth 0 wins");

        // R7 no-execute
        wr_cfg(0, 3, 32'h0000_0000);
        wr_cfg(1, 3, aword(1, 19, 0, 3, 1, 8'h33));
        access(32'h0000_1000, 0, 1'b1, "R7 fetch from xn");
        access(32'h0000_1000, 1, 1'b1, "R7 read from xn");
        access(32'h2000_1000, 0, 1'b0, "R7 fetch from executable");

        // R6 access code sweep on minimum 256 B window (R3 minimum)
        wr_cfg(0, 4, 32'h4000_0000);
        for (int ap = 0; ap < 8; ap++) begin
            wr_cfg(1, 4, aword(1, 7, 0, ap, 0, 8'h55));
            for (int p = 0; p < 2; p++) begin
                access(32'h4000_00F0, 1, p[0], "R6 read");
                access(32'h4000_00F0, 2, p[0], "R6 write");
            end
        end
        access(32'h4000_0100, 1, 1'b1, "R3 minimum window edge");

        // R3 undersized code never matches
        wr_cfg(0, 6, 32'h5000_0000);
        wr_cfg(1, 6, aword(1, 6, 0, 3, 0, 8'h66));
        access(32'h5000_0010, 1, 1'b1, "R3 undersized no match");

        // R8 background map
        wr_cfg(2, 0, 32'h0000_0003);
        access(32'h5000_0010, 2, 1'b1, "R8 background privileged");
        access(32'h5000_0010, 1, 1'b0, "R8 background unprivileged");

        // R3 4 GB window, R10 system area
        wr_cfg(1, 5, aword(1, 31, 0, 2, 0, 8'h77));
        access(32'h9000_0000, 1, 1'b0, "R3 4GB read");
        access(32'h9000_0000, 2, 1'b0, "R3 4GB write");
        access(32'hE000_E010, 2, 1'b0, "R10 system area write");
        access(32'hEFFF_FFFC, 0, 1'b0, "R10 system area fetch");
        access(32'hF000_0000, 2, 1'b0, "R10 just above system area");

        // R11 kind 3 as read, idle quiet
        access(32'h2000_0100, 3, 1'b0, "R11 kind 3 read");
        @(negedge clk);
        chk(!res_valid && !res_permit && !res_fault, "R11 idle",
            {29'd0, res_valid, res_permit, res_fault}, 32'd0);

        // R9 unit off again
        wr_cfg(2, 0, 32'h0000_0000);
        access(32'h0000_1000, 0, 1'b0, "R9 unit off over xn window");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule